// File: doc/BRIEF.md
# Interrupt Routing Register Window

This block is the bus-facing register front end of an interrupt routing controller. Software never addresses the controller's internal registers directly. It first writes an index into a select register, and then reads or writes a single data window. The index reaches a read-only version word, a 4-bit identification field, or one 32-bit half of a 64-bit routing entry. There is one routing entry per interrupt input pin.

The routing table is held in flops and exposed flat to the interrupt delivery logic. Every accepted table write raises a one-cycle strobe that carries the entry index and the half that was written. The strobe tells the delivery logic that an entry changed. If that pin's pending-request input is set at the write, a second strobe asks the delivery logic to re-evaluate the pin.

The delivery logic can set an entry's remote-IRR status bit. A write to the lower half of an entry clears that bit. Reads are combinational while the read enable is high, and the data is driven to zero when the read enable is low.

Top module: `irq_window_regs`

## Requirements
- R1: Only two bus offsets are decoded: 0x00 is the select register (read back as written) and 0x10 is the data window. Reads of any other offset return zero. Writes to any other offset change nothing.
- R2: `bus_size` encodes the access width as 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. Writes are accepted only with code 2 or 3, and only the 32 bits of `bus_wdata` are used. Narrower writes are ignored.
- R3: A window read with select 0x01 returns (PINS−1) in bits 23:16 and VERSION in bits 7:0, with all other bits zero. Window writes at select 0x01 are ignored.
- R4: Select 0x00 reads and writes a 4-bit ID held in window bits 27:24, with all other bits zero on read. Select 0x02 reads the same ID, but writes there are discarded.
- R5: A select of 0x10 or more addresses routing entry (select−0x10)>>1. An odd select accesses bits 63:32 of the entry and an even select accesses bits 31:0.
- R6: A table write whose entry index is PINS or more is dropped and raises no strobe. A table read at such an index returns zero.
- R7: Bit 14 of an entry is its remote-IRR bit. A `rirr_set` pulse sets the bit. A lower-half write replaces bits 31:0 with bit 14 forced to zero. An upper-half write leaves bits 31:0 untouched.
- R8: Each accepted table write drives `half_wr_stb` high for exactly one cycle after the write edge, with `half_wr_idx` and `half_wr_upper` naming the half. In that same cycle, `tbl_flat[64*i +: 64]` shows the new value of entry i.
- R9: `reeval_stb` pulses together with `half_wr_stb` exactly when `pend_req` of the written entry was high at the write edge.
- R10: After reset every entry is 0x0000_0000_0001_0000 (mask bit 16 set), the select register and the ID are zero, and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset within the block |
| bus_wr_en | input | 1 | Write request, one per cycle |
| bus_rd_en | input | 1 | Read request; data returned in the same cycle |
| bus_size | input | 2 | Access width code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read |
| pend_req | input | PINS | Pending-request bit per pin from delivery logic |
| rirr_set | input | PINS | Sets the remote-IRR bit of the matching entry |
| tbl_flat | output | 64*PINS | All routing entries, entry i at bits 64*i+63:64*i |
| half_wr_stb | output | 1 | One-cycle pulse after an accepted table write |
| half_wr_idx | output | IDXW | Entry index of that write |
| half_wr_upper | output | 1 | High when the upper half was written |
| reeval_stb | output | 1 | Re-evaluation request for the written pin |

## Verification
The window is tried with each kind of select value: the fixed indices 0x00, 0x01 and 0x02, even and odd table indices at the first and last entry, and the first out-of-range index. These show whether the decoder confuses the register kinds, swaps the halves, or misplaces the range limit. Writes are issued with all four size codes and to a stray offset, which shows whether the width filter and the address decode are applied before any state changes. The remote-IRR sequence sets the bit, writes the upper half and then the lower half, which separates the clearing write from the preserving one. Table writes are made with the pin's pending bit both high and low, which shows whether the re-evaluation pulse follows the pending input.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

   // Bus offsets (low 8 address bits only)
   localparam logic [7:0] OFS_SELECT = 8'h00;
   localparam logic [7:0] OFS_WINDOW = 8'h10;

   // Window indices held in the select register
   localparam logic [31:0] IDX_ID       = 32'h0000_0000;
   localparam logic [31:0] IDX_VER      = 32'h0000_0001;
   localparam logic [31:0] IDX_ARB      = 32'h0000_0002;
   localparam logic [31:0] IDX_TBL_BASE = 32'h0000_0010;

   // Routing entry fields the block itself touches
   localparam int RIRR_BIT = 14;
   localparam int MASK_BIT = 16;
   localparam int ENTRY_W  = 64;
   localparam int HALF_W   = 32;

   localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h1 << MASK_BIT;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_ID,
      TGT_VER,
      TGT_ARB,
      TGT_TBL
   } win_tgt_e;

   typedef enum logic [1:0] {
      SZ_1B = 2'd0,
      SZ_2B = 2'd1,
      SZ_4B = 2'd2,
      SZ_8B = 2'd3
   } acc_size_e;

endpackage

// File: rtl/irqw_sel_decode.sv
module irqw_sel_decode
   import irqw_pkg::*;
#(
   parameter int PINS = 24,
   localparam int IDXW = (PINS > 1) ? $clog2(PINS) : 1
)(
   input  logic [7:0]      addr,
   input  logic [31:0]     sel,
   output logic            at_select,
   output logic            at_window,
   output win_tgt_e        tgt,
   output logic [IDXW-1:0] tbl_idx,
   output logic            tbl_upper,
   output logic            tbl_in_range
);

   logic [31:0] tbl_off;
   logic [30:0] full_idx;

   assign at_select = (addr == OFS_SELECT);
   assign at_window = (addr == OFS_WINDOW);

   assign tbl_off   = sel - IDX_TBL_BASE;
   assign full_idx  = tbl_off[31:1];
   assign tbl_upper = sel[0];
   assign tbl_idx   = full_idx[IDXW-1:0];

   always_comb begin
      tbl_in_range = 1'b0;
      if (sel == IDX_ID) begin
         tgt = TGT_ID;
      end else if (sel == IDX_VER) begin
         tgt = TGT_VER;
      end else if (sel == IDX_ARB) begin
         tgt = TGT_ARB;
      end else if (sel >= IDX_TBL_BASE) begin
         tgt = TGT_TBL;
         tbl_in_range = ({1'b0, full_idx} < 32'(PINS));
      end else begin
         tgt = TGT_NONE;
      end
   end

endmodule

// File: rtl/irqw_entry_bank.sv
module irqw_entry_bank
   import irqw_pkg::*;
#(
   parameter int PINS = 24,
   localparam int IDXW = (PINS > 1) ? $clog2(PINS) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic               upper,
   input  logic [IDXW-1:0]    idx,
   input  logic [HALF_W-1:0]  wdata,
   input  logic [PINS-1:0]    rirr_set,
   output logic [ENTRY_W-1:0] entries [PINS]
);

   for (genvar gi = 0; gi < PINS; gi++) begin : g_entry
      logic hit;
      assign hit = we && (idx == IDXW'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            entries[gi] <= ENTRY_RST;
         end else if (hit && upper) begin
            entries[gi][ENTRY_W-1:HALF_W] <= wdata;
            if (rirr_set[gi]) entries[gi][RIRR_BIT] <= 1'b1;
         end else if (hit) begin
            entries[gi][HALF_W-1:0] <= wdata & ~(32'h1 << RIRR_BIT);
         end else if (rirr_set[gi]) begin
            entries[gi][RIRR_BIT] <= 1'b1;
         end
      end

      // R7: a lower-half write leaves the remote-IRR bit clear
      p_lo_clears_rirr_r7 : assert property (@(posedge clk) disable iff (!rst_n)
         (hit && !upper) |=> !entries[gi][RIRR_BIT]);

      // R7: an upper-half write keeps the lower half (remote-IRR aside)
      p_up_keeps_lo_r7 : assert property (@(posedge clk) disable iff (!rst_n)
         (hit && upper) |=> ($stable(entries[gi][RIRR_BIT-1:0]) &&
                             $stable(entries[gi][HALF_W-1:RIRR_BIT+1])));

      // R7: a set pulse without a lower write raises the bit
      p_rirr_set_r7 : assert property (@(posedge clk) disable iff (!rst_n)
         (rirr_set[gi] && !(hit && !upper)) |=> entries[gi][RIRR_BIT]);
   end

endmodule

// File: rtl/irq_window_regs.sv
module irq_window_regs
   import irqw_pkg::*;
#(
   parameter int          PINS    = 24,
   parameter logic [7:0]  VERSION = 8'h11,
   localparam int         IDXW    = (PINS > 1) ? $clog2(PINS) : 1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [7:0]             bus_addr,
   input  logic                   bus_wr_en,
   input  logic                   bus_rd_en,
   input  logic [1:0]             bus_size,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   input  logic [PINS-1:0]        pend_req,
   input  logic [PINS-1:0]        rirr_set,
   output logic [PINS*ENTRY_W-1:0] tbl_flat,
   output logic                   half_wr_stb,
   output logic [IDXW-1:0]        half_wr_idx,
   output logic                   half_wr_upper,
   output logic                   reeval_stb
);

   // Elaboration-time parameter checks
   if (PINS < 1 || PINS > 256) begin : g_bad_pins
      $error("irq_window_regs: PINS must be 1..256 so PINS-1 fits 8 bits");
   end

   localparam logic [7:0] MAX_PIN = 8'(PINS - 1);

   logic [31:0]     sel_q;
   logic [3:0]      id_q;
   logic            at_select, at_window;
   win_tgt_e        tgt;
   logic [IDXW-1:0] tbl_idx;
   logic            tbl_upper, tbl_in_range;
   logic            size_ok, wr_ok, win_wr, tbl_we;
   logic [ENTRY_W-1:0] entries [PINS];
   logic [ENTRY_W-1:0] cur_entry;

   irqw_sel_decode #(.PINS(PINS)) u_dec (
      .addr        (bus_addr),
      .sel         (sel_q),
      .at_select   (at_select),
      .at_window   (at_window),
      .tgt         (tgt),
      .tbl_idx     (tbl_idx),
      .tbl_upper   (tbl_upper),
      .tbl_in_range(tbl_in_range)
   );

   assign size_ok = (bus_size == SZ_4B) || (bus_size == SZ_8B);
   assign wr_ok   = bus_wr_en && size_ok;
   assign win_wr  = wr_ok && at_window;
   assign tbl_we  = win_wr && (tgt == TGT_TBL) && tbl_in_range;

   // Select and ID registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
      end else begin
         if (wr_ok && at_select) sel_q <= bus_wdata;
         if (win_wr && tgt == TGT_ID) id_q <= bus_wdata[27:24];
      end
   end

   irqw_entry_bank #(.PINS(PINS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (tbl_we),
      .upper   (tbl_upper),
      .idx     (tbl_idx),
      .wdata   (bus_wdata),
      .rirr_set(rirr_set),
      .entries (entries)
   );

   for (genvar gi = 0; gi < PINS; gi++) begin : g_flat
      assign tbl_flat[gi*ENTRY_W +: ENTRY_W] = entries[gi];
   end

   // Write notification strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_wr_stb   <= 1'b0;
         half_wr_idx   <= '0;
         half_wr_upper <= 1'b0;
         reeval_stb    <= 1'b0;
      end else begin
         half_wr_stb <= tbl_we;
         reeval_stb  <= tbl_we && pend_req[tbl_idx];
         if (tbl_we) begin
            half_wr_idx   <= tbl_idx;
            half_wr_upper <= tbl_upper;
         end
      end
   end

   // Read path
   assign cur_entry = tbl_in_range ? entries[tbl_idx] : '0;

   always_comb begin
      bus_rdata = '0;
      if (bus_rd_en) begin
         if (at_select) begin
            bus_rdata = sel_q;
         end else if (at_window) begin
            unique case (tgt)
               TGT_VER:         bus_rdata = {8'h00, MAX_PIN, 8'h00, VERSION};
               TGT_ID, TGT_ARB: bus_rdata = {4'h0, id_q, 24'h0};
               TGT_TBL:         bus_rdata = tbl_upper ? cur_entry[ENTRY_W-1:HALF_W]
                                                      : cur_entry[HALF_W-1:0];
               default:         bus_rdata = '0;
            endcase
         end
      end
   end

   // R2: narrow writes change neither select nor ID nor the table
   p_narrow_drop_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && !size_ok) |=> ($stable(sel_q) && $stable(id_q) && !half_wr_stb));

   // R4: writes to the arbitration index never change the ID
   p_arb_ro_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && tgt == TGT_ARB) |=> $stable(id_q));

   // R6: an out-of-range table write raises no strobe
   p_oob_drop_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && tgt == TGT_TBL && !tbl_in_range) |=> !half_wr_stb);

   // R8: the strobe lasts a single cycle for a single write
   p_stb_pulse_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (half_wr_stb && !$past(tbl_we, 2)) |=> !half_wr_stb || $past(tbl_we));

   // R9: re-evaluation only comes with a write strobe
   p_reeval_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      reeval_stb |-> half_wr_stb);

   // R1: no read means zero data
   p_idle_rdata_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |-> (bus_rdata == 32'h0));

endmodule

// File: tb/test_irq_window_regs.sv
module test_irq_window_regs;
   localparam int PINS = 24;
   localparam int IDXW = $clog2(PINS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
   logic [1:0]  bus_size = 2'd2;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [PINS-1:0] pend_req = '0, rirr_set = '0;
   logic [PINS*64-1:0] tbl_flat;
   logic half_wr_stb, half_wr_upper, reeval_stb;
   logic [IDXW-1:0] half_wr_idx;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_window_regs #(.PINS(PINS), .VERSION(8'h11)) i_irq_window_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
      .bus_rd_en(bus_rd_en), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pend_req(pend_req), .rirr_set(rirr_set),
      .tbl_flat(tbl_flat), .half_wr_stb(half_wr_stb), .half_wr_idx(half_wr_idx),
      .half_wr_upper(half_wr_upper), .reeval_stb(reeval_stb));

   // vector: {op(0 write,1 read-check), addr, size, data, expected}
   localparam int NV = 24;
   localparam logic [75:0] VECS [NV] = '{
      {2'd1, 8'h00, 2'd2, 32'h0,        32'h0},          // R10 select reset
      {2'd0, 8'h00, 2'd2, 32'h1,        32'h0},
      {2'd1, 8'h10, 2'd2, 32'h0,        32'h0017_0011},  // R3
      {2'd0, 8'h10, 2'd2, 32'hFFFF_FFFF,32'h0},
      {2'd1, 8'h10, 2'd2, 32'h0,        32'h0017_0011},  // R3 write ignored
      {2'd0, 8'h00, 2'd2, 32'h0,        32'h0},
      {2'd0, 8'h10, 2'd3, 32'hFA00_00FF,32'h0},
      {2'd1, 8'h10, 2'd2, 32'h0,        32'h0A00_0000},  // R4 ID
      {2'd0, 8'h00, 2'd2, 32'h2,        32'h0},
      {2'd0, 8'h10, 2'd2, 32'h0500_0000,32'h0},
      {2'd1, 8'h10, 2'd2, 32'h0,        32'h0A00_0000},  // R4 arb
      {2'd0, 8'h00, 2'd2, 32'h10,       32'h0},
      {2'd1, 8'h10, 2'd2, 32'h0,        32'h0001_0000},  // R10 entry 0
      {2'd0, 8'h10, 2'd3, 32'h0000_A0B1,32'h0},
      {2'd0, 8'h00, 2'd2, 32'h11,       32'h0},
      {2'd0, 8'h10, 2'd2, 32'hDEAD_BEEF,32'h0},
      {2'd1, 8'h10, 2'd2, 32'h0,        32'hDEAD_BEEF},  // R5 upper
      {2'd0, 8'h00, 2'd2, 32'h10,       32'h0},
      {2'd1, 8'h10, 2'd2, 32'h0,        32'h0000_A0B1},  // R5 lower
      {2'd0, 8'h00, 2'd2, 32'h3F,       32'h0},
      {2'd0, 8'h10, 2'd2, 32'h1234_5678,32'h0},
      {2'd1, 8'h10, 2'd2, 32'h0,        32'h1234_5678},  // R5 last entry
      {2'd0, 8'h20, 2'd2, 32'h55,       32'h0},
      {2'd1, 8'h20, 2'd2, 32'h0,        32'h0}           // R1 stray offset
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a; bus_rd_en = 1'b1;
      #1;
      check(req, {32'h0, bus_rdata}, {32'h0, exp});
      bus_rd_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      #1;
      check("R10 strobes", {61'h0, half_wr_stb, reeval_stb, half_wr_upper}, 64'h0);
      for (int i = 0; i < PINS; i++)
         check("R10 entry", tbl_flat[i*64 +: 64], 64'h0000_0000_0001_0000);

      for (int v = 0; v < NV; v++) begin
         if (VECS[v][75:74] == 2'd0)
            wr(VECS[v][73:66], VECS[v][65:64], VECS[v][63:32]);
         else
            rd("R1-R5 vector", VECS[v][73:66], VECS[v][31:0]);
      end

      // R6 out-of-range write dropped, read zero
      wr(8'h00, 2'd2, 32'h40);
      wr(8'h10, 2'd2, 32'h1);
      check("R6 no strobe", {63'h0, half_wr_stb}, 64'h0);
      rd("R6 oob read", 8'h10, 32'h0);

      // R2 narrow writes ignored
      wr(8'h00, 2'd1, 32'h3F);
      rd("R2 sel narrow", 8'h00, 32'h40);
      wr(8'h00, 2'd2, 32'h3F);
      wr(8'h10, 2'd0, 32'hFFFF);
      check("R2 no strobe", {63'h0, half_wr_stb}, 64'h0);
      rd("R2 window narrow", 8'h10, 32'h1234_5678);

      // R7 remote-IRR handling on entry 3
      @(negedge clk); rirr_set = 24'h8;
      @(negedge clk); rirr_set = '0;
      rd("R7 set", 8'h10, 32'h1234_5678);
      wr(8'h00, 2'd2, 32'h16);
      rd("R7 set visible", 8'h10, 32'h0001_4000);
      wr(8'h00, 2'd2, 32'h17);
      wr(8'h10, 2'd2, 32'hAB00_0000);
      wr(8'h00, 2'd2, 32'h16);
      rd("R7 upper keeps", 8'h10, 32'h0001_4000);
      wr(8'h10, 2'd2, 32'h0000_4021);
      // R8 strobe right after the write edge
      check("R8 stb", {63'h0, half_wr_stb}, 64'h1);
      check("R8 idx", {{(64-IDXW){1'b0}}, half_wr_idx}, 64'd3);
      check("R8 upper", {63'h0, half_wr_upper}, 64'h0);
      check("R8 table", tbl_flat[3*64 +: 64], 64'hAB00_0000_0000_0021);
      check("R9 no pend", {63'h0, reeval_stb}, 64'h0);
      @(negedge clk);
      check("R8 one cycle", {63'h0, half_wr_stb}, 64'h0);
      rd("R7 lower clears", 8'h10, 32'h0000_0021);

      // R9 re-evaluation follows pending input
      pend_req = 24'h20;
      wr(8'h00, 2'd2, 32'h1A);
      wr(8'h10, 2'd3, 32'h0000_0030);
      check("R9 reeval", {62'h0, half_wr_stb, reeval_stb}, 64'h3);
      check("R9 idx", {{(64-IDXW){1'b0}}, half_wr_idx}, 64'd5);
      pend_req = '0;
      wr(8'h00, 2'd2, 32'h1B);
      wr(8'h10, 2'd2, 32'h0F00_0000);
      check("R9 no reeval", {62'h0, half_wr_stb, reeval_stb}, 64'h2);
      check("R8 upper flag", {63'h0, half_wr_upper}, 64'h1);
      check("R8 table 5", tbl_flat[5*64 +: 64], 64'h0F00_0000_0000_0030);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule